// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the state store and selector of a small interrupt controller. It keeps, for every interrupt line, an enable bit, a pending bit, a trigger mode, an 8-bit priority and an 8-bit target mask. It serves up to eight processor interfaces. Software reaches this state through a simple word-addressed read/write port. The requester-ID input tells the block which processor is making each access.

IDs 0 to 31 are private. Each processor has its own copy of their enable and pending bits, and its own set of 32 private input wires. Lines 32 and up are shared, and their target masks route them to processors. For each processor the block keeps a registered result: the enabled, pending and targeted line with the best priority. Acknowledge and end-of-interrupt handling are left to a separate block.

Word map (word addresses): control 0x000, type 0x001, enable-set 0x040+k, enable-clear 0x060+k, pending (read) / pending-clear (write) 0x080+k, priority 0x100+w, targets 0x200+w, trigger configuration 0x300+c. Here k = id/32, w = id/4 and c = id/16.

Top module: `intd_dist`

## Requirements
- R1: After reset the control bit, all enables, all priorities, all shared targets and all shared trigger modes are 0, `rdata` is 0 and no `sel_valid` bit is set.
- R2: A write to enable-set word k sets every enable whose `wdata` bit is 1. A write to enable-clear word k clears every such enable. Bits written as 0 are unchanged, and reading either address returns the current enables of word k.
- R3: Enable and pending word 0 (IDs 0 to 31) are banked. A write or read selects the copy of the processor given by `req_id`, and the other processors' copies are untouched.
- R4: Each trigger field is 2 bits at position 2*(id%16) of word c. The upper bit 1 means edge and 0 means level, and the lower bit always reads 0. Word 0 (IDs 0 to 15) always reads 0xAAAAAAAA, and writes to it are ignored.
- R5: An edge line becomes pending when its input goes from 0 to 1. It stays pending after the input falls, until a 1 is written to its bit of the pending-clear word.
- R6: A level line is pending exactly while its input is high. Its pending bit reads back at bit id%32 of pending word k.
- R7: Priority and target of ID n sit in bits 8*(n%4)+7 : 8*(n%4) of their word, and read back as written.
- R8: Target words 0 to 7 (the private IDs) ignore writes. Each of their bytes reads as the one-hot mask 1<<`req_id`.
- R9: For each processor, the result is the line that is enabled, pending and targeted at that processor that has the lowest priority value, with ties going to the lower ID. Private lines go only to their owning processor. A shared line goes to processor p only if bit p of its target mask is set.
- R10: While control bit 0 is clear, no `sel_valid` bit is set.
- R11: The type register returns NUM_LINES/32-1 in bits 4:0.
- R12: Read data appears on `rdata` one cycle after `rd_en`. A selection result reflects an input change two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| req_id | input | CPU_W | Processor making the access |
| rdata | output | 32 | Registered read data |
| priv_irq | input | NUM_CPUS*32 | Private interrupt inputs, 32 per processor |
| shared_irq | input | NUM_LINES-32 | Shared interrupt inputs for IDs 32 and up |
| sel_valid | output | NUM_CPUS | A line is presented to the processor |
| sel_id | output | NUM_CPUS*10 | ID of the presented line, per processor |
| sel_prio | output | NUM_CPUS*8 | Priority of the presented line, per processor |

## Verification
The bench targets the ways banking can leak. One processor sets a private enable and the other reads the same word. A design that ignored `req_id` would return the other processor's bits. The bench also checks a priority tie between two lines and then breaks the tie. A selector using a non-strict compare would pick the higher ID on a tie. It pulses an edge line for a single cycle and confirms the line stays presented until its pending bit is cleared. A design that treated the line as level would drop it. Finally it writes to the read-only trigger word and the private target words. A missing write guard shows up as changed read-back values.

// File: rtl/intd_pkg.sv
package intd_pkg;
  localparam int ID_W = 10;
  localparam int AW   = 10;
  localparam logic [AW-1:0] A_CTRL  = 10'h000;
  localparam logic [AW-1:0] A_TYPE  = 10'h001;
  localparam logic [AW-1:0] A_ENSET = 10'h040;
  localparam logic [AW-1:0] A_ENCLR = 10'h060;
  localparam logic [AW-1:0] A_PEND  = 10'h080;
  localparam logic [AW-1:0] A_PRIO  = 10'h100;
  localparam logic [AW-1:0] A_TGT   = 10'h200;
  localparam logic [AW-1:0] A_CFG   = 10'h300;
endpackage

// File: rtl/intd_pending.sv
module intd_pending #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] irq_in,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] in_q;
  logic [W-1:0] lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
      lat  <= '0;
    end else begin
      in_q <= irq_in;
      lat  <= (lat & ~clr) | (irq_in & ~in_q);
    end
  end

  assign pend = (edge_mode & lat) | (~edge_mode & in_q);

  // R5: a latched edge survives unless a clear arrived
  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(lat) & ~$past(clr) & ~lat) == '0));
endmodule

// File: rtl/intd_select.sv
module intd_select #(
  parameter int N    = 64,
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [N-1:0]    cand,
  input  logic [N*8-1:0]  prio,
  output logic            valid,
  output logic [ID_W-1:0] id,
  output logic [7:0]      prio_out
);
  logic            best_v;
  logic [7:0]      best_p;
  logic [ID_W-1:0] best_i;

  always_comb begin
    best_v = 1'b0;
    best_p = 8'hFF;
    best_i = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!best_v || prio[i*8+:8] < best_p)) begin
        best_v = 1'b1;
        best_p = prio[i*8+:8];
        best_i = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      id       <= '0;
      prio_out <= '0;
    end else begin
      valid    <= en && best_v;
      id       <= best_i;
      prio_out <= best_p;
    end
  end

  // R10: forwarding disabled means nothing presented next cycle
  a_r10_gate_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid);
  // R9: the presented line was a candidate
  a_r9_winner_pending: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((($past(cand) >> id) & N'(1)) != '0));
endmodule

// File: rtl/intd_dist.sv
module intd_dist #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 64,
  parameter int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [9:0]                addr,
  input  logic [31:0]               wdata,
  input  logic [CPU_W-1:0]          req_id,
  output logic [31:0]               rdata,
  input  logic [NUM_CPUS*32-1:0]    priv_irq,
  input  logic [NUM_LINES-33:0]     shared_irq,
  output logic [NUM_CPUS-1:0]       sel_valid,
  output logic [NUM_CPUS*10-1:0]    sel_id,
  output logic [NUM_CPUS*8-1:0]     sel_prio
);
  import intd_pkg::*;

  localparam int NW = NUM_LINES / 32;
  localparam int NP = NUM_LINES / 4;
  localparam int NC = NUM_LINES / 16;
  localparam int SH = NUM_LINES - 32;

  logic                       ctrl_en;
  logic [NUM_CPUS-1:0][31:0]  priv_en;
  logic [SH-1:0]              sh_en;
  logic [NUM_LINES-1:0][7:0]  prio;
  logic [SH-1:0][7:0]         tgt;
  logic [NUM_LINES-17:0]      cfg_q;
  logic [NUM_LINES-1:0]       edge_cfg;
  logic [NUM_CPUS-1:0][31:0]  priv_pend;
  logic [NUM_CPUS-1:0][31:0]  pclr_priv;
  logic [SH-1:0]              sh_pend;
  logic [SH-1:0]              pclr_sh;
  logic [31:0]                rd_val;
  logic [7:0]                 own_mask;

  assign edge_cfg = {cfg_q, 16'hFFFF};
  assign own_mask = 8'(1) << req_id;

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      priv_en <= '0;
      sh_en   <= '0;
      prio    <= '0;
      tgt     <= '0;
      cfg_q   <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_en <= wdata[0];
      if (addr == A_ENSET) priv_en[req_id] <= priv_en[req_id] | wdata;
      if (addr == A_ENCLR) priv_en[req_id] <= priv_en[req_id] & ~wdata;
      for (int k = 1; k < NW; k++) begin
        if (addr == A_ENSET + AW'(k)) sh_en[(k-1)*32+:32] <= sh_en[(k-1)*32+:32] | wdata;
        if (addr == A_ENCLR + AW'(k)) sh_en[(k-1)*32+:32] <= sh_en[(k-1)*32+:32] & ~wdata;
      end
      for (int w = 0; w < NP; w++) begin
        if (addr == A_PRIO + AW'(w))
          for (int j = 0; j < 4; j++) prio[4*w+j] <= wdata[8*j+:8];
      end
      for (int w = 8; w < NP; w++) begin
        if (addr == A_TGT + AW'(w))
          for (int j = 0; j < 4; j++) tgt[4*w+j-32] <= wdata[8*j+:8];
      end
      for (int c = 1; c < NC; c++) begin
        if (addr == A_CFG + AW'(c))
          for (int f = 0; f < 16; f++) cfg_q[16*c+f-16] <= wdata[2*f+1];
      end
    end
  end

  // pending-clear strobes
  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++)
      pclr_priv[c] = (wr_en && addr == A_PEND && int'(req_id) == c) ? wdata : '0;
    pclr_sh = '0;
    for (int k = 1; k < NW; k++)
      if (wr_en && addr == A_PEND + AW'(k)) pclr_sh[(k-1)*32+:32] = wdata;
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (addr == A_CTRL) rd_val[0] = ctrl_en;
    if (addr == A_TYPE) rd_val[4:0] = 5'(NW - 1);
    if (addr == A_ENSET || addr == A_ENCLR) rd_val = priv_en[req_id];
    if (addr == A_PEND) rd_val = priv_pend[req_id];
    for (int k = 1; k < NW; k++) begin
      if (addr == A_ENSET + AW'(k) || addr == A_ENCLR + AW'(k)) rd_val = sh_en[(k-1)*32+:32];
      if (addr == A_PEND + AW'(k)) rd_val = sh_pend[(k-1)*32+:32];
    end
    for (int w = 0; w < NP; w++)
      if (addr == A_PRIO + AW'(w)) rd_val = {prio[4*w+3], prio[4*w+2], prio[4*w+1], prio[4*w]};
    for (int w = 0; w < 8; w++)
      if (addr == A_TGT + AW'(w)) rd_val = {4{own_mask}};
    for (int w = 8; w < NP; w++)
      if (addr == A_TGT + AW'(w)) rd_val = {tgt[4*w-29], tgt[4*w-30], tgt[4*w-31], tgt[4*w-32]};
    if (addr == A_CFG) rd_val = 32'hAAAA_AAAA;
    for (int c = 1; c < NC; c++)
      if (addr == A_CFG + AW'(c))
        for (int f = 0; f < 16; f++) rd_val[2*f+1] = cfg_q[16*c+f-16];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // pending state
  intd_pending #(.W(SH)) u_sh_pend (
    .clk(clk), .rst(rst), .irq_in(shared_irq), .edge_mode(edge_cfg[NUM_LINES-1:32]),
    .clr(pclr_sh), .pend(sh_pend)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_LINES-1:0] cand;

    intd_pending #(.W(32)) u_priv_pend (
      .clk(clk), .rst(rst), .irq_in(priv_irq[c*32+:32]), .edge_mode(edge_cfg[31:0]),
      .clr(pclr_priv[c]), .pend(priv_pend[c])
    );

    always_comb begin
      cand[31:0] = priv_en[c] & priv_pend[c];
      for (int i = 0; i < SH; i++) cand[32+i] = sh_en[i] & sh_pend[i] & tgt[i][c];
    end

    intd_select #(.N(NUM_LINES), .ID_W(ID_W)) u_sel (
      .clk(clk), .rst(rst), .en(ctrl_en), .cand(cand), .prio(prio),
      .valid(sel_valid[c]), .id(sel_id[c*10+:10]), .prio_out(sel_prio[c*8+:8])
    );

    // R3: a write by another processor leaves this bank alone
    a_r3_bank_isolated: assert property (@(posedge clk) disable iff (rst)
      (wr_en && int'(req_id) != c) |=> $stable(priv_en[c]));
  end

  // R2: an enable-set write never drops a shared enable
  a_r2_set_monotonic: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr >= A_ENSET + AW'(1) && addr < A_ENSET + AW'(NW)) |=> (($past(sh_en) & ~sh_en) == '0));
endmodule

// File: tb/intd_dist_bench.sv
module intd_dist_bench;
  localparam int NC = 2;
  localparam int NL = 64;

  logic              clk = 0;
  logic              rst = 1;
  logic              wr_en = 0, rd_en = 0;
  logic [9:0]        addr = 0;
  logic [31:0]       wdata = 0;
  logic [0:0]        req_id = 0;
  logic [31:0]       rdata;
  logic [NC*32-1:0]  priv_irq = '0;
  logic [NL-33:0]    shared_irq = '0;
  logic [NC-1:0]     sel_valid;
  logic [NC*10-1:0]  sel_id;
  logic [NC*8-1:0]   sel_prio;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] r;

  always #5 clk = ~clk;

  intd_dist #(.NUM_CPUS(NC), .NUM_LINES(NL)) u_intd_dist (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .req_id(req_id), .rdata(rdata), .priv_irq(priv_irq), .shared_irq(shared_irq),
    .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, logic rid);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; req_id = rid;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [9:0] a, logic rid);
    @(negedge clk); rd_en = 1; addr = a; req_id = rid;
    @(negedge clk); rd_en = 0; r = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] sel_word(int c);
    return {sel_valid[c], 11'd0, sel_prio[c*8+:8], 2'd0, sel_id[c*10+:10]};
  endfunction

  task automatic t_reset();
    chk("R1 rdata", rdata, 0);
    chk("R1 valid", 32'(sel_valid), 0);
    rd(10'h000, 0); chk("R1 ctrl", r, 0);
    rd(10'h041, 0); chk("R1 enable", r, 0);
    rd(10'h109, 0); chk("R1 prio", r, 0);
  endtask

  task automatic t_type();
    rd(10'h001, 1); chk("R11 type", r, 32'd1);
  endtask

  task automatic t_enable();
    wr(10'h041, 32'h0000_00F0, 0);
    rd(10'h041, 0); chk("R2 set read", r, 32'hF0);
    rd(10'h061, 0); chk("R2 clr addr read", r, 32'hF0);
    wr(10'h041, 32'h0, 0);
    rd(10'h041, 0); chk("R2 zero set", r, 32'hF0);
    wr(10'h061, 32'h30, 0);
    rd(10'h061, 0); chk("R2 clear", r, 32'hC0);
    wr(10'h061, 32'h0, 0);
    rd(10'h041, 0); chk("R2 zero clear", r, 32'hC0);
    wr(10'h061, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_bank();
    wr(10'h040, 32'h0001_0000, 0);
    rd(10'h040, 1); chk("R3 other bank", r, 0);
    rd(10'h040, 0); chk("R3 own bank", r, 32'h0001_0000);
    wr(10'h060, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_cfg();
    rd(10'h300, 0); chk("R4 fixed word", r, 32'hAAAA_AAAA);
    wr(10'h300, 32'h0, 0);
    rd(10'h300, 0); chk("R4 fixed after write", r, 32'hAAAA_AAAA);
    wr(10'h302, 32'h0000_000F, 0);
    rd(10'h302, 0); chk("R4 edge field", r, 32'h0000_000A);
    wr(10'h302, 32'h0000_0008, 0);
  endtask

  task automatic t_lanes();
    wr(10'h109, 32'h4433_2211, 0);
    rd(10'h109, 1); chk("R7 prio lanes", r, 32'h4433_2211);
    wr(10'h20B, 32'h0102_0301, 1);
    rd(10'h20B, 0); chk("R7 target lanes", r, 32'h0102_0301);
    wr(10'h109, 32'h0, 0);
    wr(10'h20B, 32'h0, 0);
  endtask

  task automatic t_privtgt();
    rd(10'h203, 0); chk("R8 cpu0 mask", r, 32'h0101_0101);
    wr(10'h203, 32'hFFFF_FFFF, 1);
    rd(10'h203, 1); chk("R8 cpu1 mask", r, 32'h0202_0202);
  endtask

  task automatic t_level();
    wr(10'h000, 1, 0);
    wr(10'h20A, 32'h0000_0101, 0);
    wr(10'h10A, 32'h0000_8080, 0);
    wr(10'h041, 32'h0000_0300, 0);
    @(negedge clk); shared_irq[8] = 1;
    @(negedge clk); @(negedge clk);
    chk("R12 two-edge latency", sel_word(0), {1'b1, 11'd0, 8'h80, 2'd0, 10'd40});
    chk("R9 not targeted", 32'(sel_valid[1]), 0);
    rd(10'h081, 0); chk("R6 pending read", r, 32'h0000_0100);
    shared_irq[8] = 0; settle();
    chk("R6 level drop", 32'(sel_valid[0]), 0);
  endtask

  task automatic t_prio();
    shared_irq[8] = 1; shared_irq[9] = 1; settle();
    chk("R9 tie lower id", sel_word(0), {1'b1, 11'd0, 8'h80, 2'd0, 10'd40});
    wr(10'h10A, 32'h0000_2080, 0); settle();
    chk("R9 lower value wins", sel_word(0), {1'b1, 11'd0, 8'h20, 2'd0, 10'd41});
    wr(10'h000, 0, 0); settle();
    chk("R10 gate off", 32'(sel_valid), 0);
    wr(10'h000, 1, 0);
    shared_irq[8] = 0; shared_irq[9] = 0; settle();
    chk("R6 both dropped", 32'(sel_valid), 0);
  endtask

  task automatic t_edge();
    wr(10'h208, 32'h0000_0200, 0);
    wr(10'h108, 32'h0000_1000, 0);
    wr(10'h041, 32'h0000_0002, 0);
    @(negedge clk); shared_irq[1] = 1;
    @(negedge clk); shared_irq[1] = 0;
    settle();
    chk("R5 edge held", sel_word(1), {1'b1, 11'd0, 8'h10, 2'd0, 10'd33});
    rd(10'h081, 0); chk("R5 pending bit", r, 32'h0000_0002);
    wr(10'h081, 32'h0000_0002, 0); settle();
    chk("R5 cleared", 32'(sel_valid[1]), 0);
  endtask

  task automatic t_private();
    wr(10'h040, 32'h0010_0000, 1);
    wr(10'h040, 32'h0010_0000, 0);
    wr(10'h105, 32'h0000_0005, 0);
    @(negedge clk); priv_irq[32+20] = 1; settle();
    chk("R9 private owner", sel_word(1), {1'b1, 11'd0, 8'h05, 2'd0, 10'd20});
    chk("R3 private not other", 32'(sel_valid[0]), 0);
    priv_irq[32+20] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_type(); t_enable(); t_bank(); t_cfg(); t_lanes();
    t_privtgt(); t_level(); t_prio(); t_edge(); t_private();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule